// File: doc/BRIEF.md
# Microcoded Memory Cycle Sequencer

This block produces the control signals for an external memory by replaying words from a small writable pattern store. Each stored word supplies one clock's worth of control outputs. It also carries two flags. One marks a data beat, which the block reports on a per-beat acknowledge strobe. The other marks the final word of a pattern. A host loads the store before traffic starts. The host also sets a mode register, which holds an operation code, a pattern start index and a burst-inhibit bit.

Each bus request carries an address, a byte count and a read/write flag. The block maps the request to one or more pattern runs.

- A request takes the burst pattern when it is line-aligned, its length is a whole number of lines, and burst is not inhibited. The burst pattern then runs once per line.
- Every other request becomes a series of back-to-back single-beat runs.
- When the operation code is the run code, a write request starts one run of the pattern at the index held in the mode register. This is how special sequences are issued, such as device initialisation or self-refresh entry.

Top module: `ucode_seq`

## Requirements
- R1: After reset, `mem_ctl` is zero and `beat_ack`, `busy`, `done` and `err` are all low. While `busy` is low, `mem_ctl` stays zero and `beat_ack` stays low.
- R2: Each store word has this layout: bits [15:0] are the control value, bit 16 is the beat flag and bit 17 is the final-word flag.
  - In the cycle after a request is accepted, `busy` rises and `mem_ctl`/`beat_ack` show the word at the start index.
  - Execution then advances one index per cycle and stops after the first word with the final-word flag set.
  - `done` is high for exactly one cycle, in the cycle after the last word, and `busy` is low in that cycle.
- R3: A request that is handled as single-beat starts at index 0 for a read and at index 24 for a write.
- R4: A burst is used only when all of these hold: address bits [4:0] are zero, the length is a non-zero multiple of 32, and burst inhibit is clear. A burst starts at index 8 for a read and at index 32 for a write. The burst pattern runs length/32 times back to back, with no idle cycle between runs.
- R5: A request that does not fit a burst runs the single-beat pattern ceil(length/4) times back to back. A length of 0 runs it once.
- R6: With burst inhibit set, an aligned whole-line request is still handled as ceil(length/4) single-beat runs.
- R7: With operation code 2'b11, a write request runs the pattern once, starting at the mode register's start index. A read request under that code is handled as an ordinary read.
- R8: While `busy` is high, a request is ignored. It neither changes the running sequence nor starts a run once the sequence ends.
- R9: If index 63 is reached without a final-word flag, execution stops after that word with no `done` pulse. `err` then rises and stays high until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ram_we | input | 1 | Pattern store write enable |
| ram_addr | input | 6 | Pattern store write index |
| ram_wdata | input | 18 | Pattern word: last flag, beat flag, control value |
| mode_we | input | 1 | Mode register write enable |
| mode_op | input | 2 | Operation code; 2'b11 selects run-from-index |
| mode_start | input | 6 | Start index for the run operation |
| mode_nobrst | input | 1 | Burst inhibit |
| req_valid | input | 1 | Bus request present |
| req_addr | input | 32 | Request byte address |
| req_len | input | 8 | Request byte count |
| req_write | input | 1 | 1 for write, 0 for read |
| mem_ctl | output | 16 | Memory control outputs |
| beat_ack | output | 1 | Per-beat acknowledge strobe |
| busy | output | 1 | Pattern executing |
| done | output | 1 | One-cycle completion pulse |
| err | output | 1 | Sticky missing-final-word flag |

## Verification
The bench builds the block with its default parameters. With those values it has a 64-word store, 16 control bits, 32-byte lines and 4-byte beats. Under these settings:
- A single-line burst pattern delivers eight acknowledges.
- The 8-bit byte count reaches 64 back-to-back single runs.
- Burst requests of up to three lines occur in the random mix.
- The overrun error is reached by starting a run at index 52, from which execution reaches index 63.

// File: rtl/ucode_seq_pkg.sv
package ucode_seq_pkg;
   typedef enum logic [1:0] {
      OP_NORMAL = 2'b00,
      OP_RES_A  = 2'b01,
      OP_RES_B  = 2'b10,
      OP_RUN    = 2'b11
   } seq_op_e;

   typedef enum logic {
      S_IDLE = 1'b0,
      S_RUN  = 1'b1
   } seq_state_e;
endpackage

// File: rtl/ucode_seq_ram.sv
module ucode_seq_ram #(
   parameter int DEPTH  = 64,
   parameter int WORD_W = 18,
   localparam int IDX_W = $clog2(DEPTH)
) (
   input  logic              clk,
   input  logic              we,
   input  logic [IDX_W-1:0]  waddr,
   input  logic [WORD_W-1:0] wdata,
   input  logic [IDX_W-1:0]  raddr,
   output logic [WORD_W-1:0] rdata
);
   logic [WORD_W-1:0] mem_q [DEPTH];

   always_ff @(posedge clk) begin
      if (we) mem_q[waddr] <= wdata;
   end

   assign rdata = mem_q[raddr];
endmodule

// File: rtl/ucode_seq_plan.sv
module ucode_seq_plan
   import ucode_seq_pkg::*;
#(
   parameter int ADDR_W     = 32,
   parameter int LEN_W      = 8,
   parameter int IDX_W      = 6,
   parameter int LINE_BYTES = 32,
   parameter int BEAT_BYTES = 4,
   parameter int RD_SGL_IDX = 0,
   parameter int RD_BST_IDX = 8,
   parameter int WR_SGL_IDX = 24,
   parameter int WR_BST_IDX = 32
) (
   input  logic [ADDR_W-1:0] addr,
   input  logic [LEN_W-1:0]  len,
   input  logic              wr,
   input  seq_op_e           op,
   input  logic [IDX_W-1:0]  run_idx,
   input  logic              nobrst,
   output logic [IDX_W-1:0]  start_idx,
   output logic [LEN_W-1:0]  run_cnt
);
   localparam int LINE_SH = $clog2(LINE_BYTES);
   localparam int BEAT_SH = $clog2(BEAT_BYTES);
   localparam logic [LEN_W:0] BEAT_RND = (LEN_W+1)'(BEAT_BYTES - 1);

   logic              aligned, whole, fits;
   logic [LEN_W-1:0]  n_bst, n_sgl;
   logic              unused_addr_hi;

   assign unused_addr_hi = ^addr[ADDR_W-1:LINE_SH];
   assign aligned = (addr[LINE_SH-1:0] == '0);
   assign whole   = (len[LINE_SH-1:0] == '0) && (len != '0);
   assign fits    = !nobrst && aligned && whole;
   assign n_bst   = len >> LINE_SH;

   generate
      if (BEAT_SH == 0) begin : g_byte_beats
         assign n_sgl = (len == '0) ? LEN_W'(1) : len;
      end else begin : g_wide_beats
         logic [LEN_W:0] rounded;
         assign rounded = {1'b0, len} + BEAT_RND;
         assign n_sgl   = (len == '0) ? LEN_W'(1) : LEN_W'(rounded >> BEAT_SH);
      end
   endgenerate

   always_comb begin
      if (op == OP_RUN && wr) begin
         start_idx = run_idx;
         run_cnt   = LEN_W'(1);
      end else if (fits) begin
         start_idx = wr ? IDX_W'(WR_BST_IDX) : IDX_W'(RD_BST_IDX);
         run_cnt   = n_bst;
      end else begin
         start_idx = wr ? IDX_W'(WR_SGL_IDX) : IDX_W'(RD_SGL_IDX);
         run_cnt   = n_sgl;
      end
   end
endmodule

// File: rtl/ucode_seq_exec.sv
module ucode_seq_exec
   import ucode_seq_pkg::*;
#(
   parameter int DEPTH = 64,
   parameter int CTL_W = 16,
   parameter int LEN_W = 8,
   localparam int IDX_W  = $clog2(DEPTH),
   localparam int WORD_W = CTL_W + 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_valid,
   input  logic [IDX_W-1:0]  start_idx,
   input  logic [LEN_W-1:0]  run_cnt,
   input  logic [WORD_W-1:0] word,
   output logic [IDX_W-1:0]  rd_idx,
   output logic [CTL_W-1:0]  ctl,
   output logic              ack,
   output logic              busy,
   output logic              done,
   output logic              err
);
   localparam logic [IDX_W-1:0] END_IDX = IDX_W'(DEPTH - 1);

   seq_state_e        state_q;
   logic [IDX_W-1:0]  ptr_q, base_q;
   logic [LEN_W-1:0]  left_q;
   logic              done_q, err_q;
   logic              word_last, word_ack;

   assign word_last = word[CTL_W+1];
   assign word_ack  = word[CTL_W];
   assign busy      = (state_q == S_RUN);
   assign rd_idx    = ptr_q;
   assign ctl       = busy ? word[CTL_W-1:0] : '0;
   assign ack       = busy & word_ack;
   assign done      = done_q;
   assign err       = err_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= S_IDLE;
         ptr_q   <= '0;
         base_q  <= '0;
         left_q  <= '0;
         done_q  <= 1'b0;
         err_q   <= 1'b0;
      end else begin
         done_q <= 1'b0;
         unique case (state_q)
            S_IDLE: begin
               if (req_valid) begin
                  state_q <= S_RUN;
                  ptr_q   <= start_idx;
                  base_q  <= start_idx;
                  left_q  <= (run_cnt == '0) ? LEN_W'(1) : run_cnt;
               end
            end
            S_RUN: begin
               if (word_last) begin
                  if (left_q == LEN_W'(1)) begin
                     state_q <= S_IDLE;
                     done_q  <= 1'b1;
                  end else begin
                     left_q <= left_q - LEN_W'(1);
                     ptr_q  <= base_q;
                  end
               end else if (ptr_q == END_IDX) begin
                  state_q <= S_IDLE;
                  err_q   <= 1'b1;
               end else begin
                  ptr_q <= ptr_q + IDX_W'(1);
               end
            end
            default: state_q <= S_IDLE;
         endcase
      end
   end

   // R2: a beat strobe only appears while a pattern executes
   p_ack_in_run_r2: assert property (@(posedge clk) disable iff (!rst_n)
      ack |-> busy);
   // R1: control outputs rest at zero when idle
   p_idle_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
      !busy |-> (ctl == '0));
   // R2: every end of execution is either a completion or an overrun
   p_end_reported_r2: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(busy) |-> (done || err));
   // R8: the pattern base cannot be changed by a request during a run
   p_base_held_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == S_RUN) |=> (state_q == S_IDLE || base_q == $past(base_q)));
   // R9: the overrun flag never clears outside reset
   p_err_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
      err |=> err);
endmodule

// File: rtl/ucode_seq.sv
module ucode_seq
   import ucode_seq_pkg::*;
#(
   parameter int DEPTH      = 64,
   parameter int CTL_W      = 16,
   parameter int ADDR_W     = 32,
   parameter int LEN_W      = 8,
   parameter int LINE_BYTES = 32,
   parameter int BEAT_BYTES = 4,
   parameter int RD_SGL_IDX = 0,
   parameter int RD_BST_IDX = 8,
   parameter int WR_SGL_IDX = 24,
   parameter int WR_BST_IDX = 32,
   localparam int IDX_W  = $clog2(DEPTH),
   localparam int WORD_W = CTL_W + 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              ram_we,
   input  logic [IDX_W-1:0]  ram_addr,
   input  logic [WORD_W-1:0] ram_wdata,
   input  logic              mode_we,
   input  logic [1:0]        mode_op,
   input  logic [IDX_W-1:0]  mode_start,
   input  logic              mode_nobrst,
   input  logic              req_valid,
   input  logic [ADDR_W-1:0] req_addr,
   input  logic [LEN_W-1:0]  req_len,
   input  logic              req_write,
   output logic [CTL_W-1:0]  mem_ctl,
   output logic              beat_ack,
   output logic              busy,
   output logic              done,
   output logic              err
);
   generate
      if (DEPTH < 2) begin : g_bad_depth
         $error("ucode_seq: DEPTH must be at least 2");
      end
      if ((LINE_BYTES & (LINE_BYTES - 1)) != 0 || LINE_BYTES < 2) begin : g_bad_line
         $error("ucode_seq: LINE_BYTES must be a power of two, at least 2");
      end
      if ((BEAT_BYTES & (BEAT_BYTES - 1)) != 0 || BEAT_BYTES > LINE_BYTES) begin : g_bad_beat
         $error("ucode_seq: BEAT_BYTES must be a power of two not above LINE_BYTES");
      end
      if ($clog2(LINE_BYTES) > LEN_W || $clog2(LINE_BYTES) >= ADDR_W) begin : g_bad_width
         $error("ucode_seq: LEN_W or ADDR_W too narrow for LINE_BYTES");
      end
      if (RD_SGL_IDX >= DEPTH || RD_BST_IDX >= DEPTH ||
          WR_SGL_IDX >= DEPTH || WR_BST_IDX >= DEPTH) begin : g_bad_start
         $error("ucode_seq: fixed start index outside the pattern store");
      end
   endgenerate

   seq_op_e           op_q;
   logic [IDX_W-1:0]  run_idx_q;
   logic              nobrst_q;
   logic [IDX_W-1:0]  plan_start, rd_idx;
   logic [LEN_W-1:0]  plan_runs;
   logic [WORD_W-1:0] cur_word;
   logic              take;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         op_q      <= OP_NORMAL;
         run_idx_q <= '0;
         nobrst_q  <= 1'b0;
      end else if (mode_we) begin
         op_q      <= seq_op_e'(mode_op);
         run_idx_q <= mode_start;
         nobrst_q  <= mode_nobrst;
      end
   end

   assign take = req_valid && !busy;

   ucode_seq_ram #(.DEPTH(DEPTH), .WORD_W(WORD_W)) u_ram (
      .clk   (clk),
      .we    (ram_we),
      .waddr (ram_addr),
      .wdata (ram_wdata),
      .raddr (rd_idx),
      .rdata (cur_word)
   );

   ucode_seq_plan #(
      .ADDR_W(ADDR_W), .LEN_W(LEN_W), .IDX_W(IDX_W),
      .LINE_BYTES(LINE_BYTES), .BEAT_BYTES(BEAT_BYTES),
      .RD_SGL_IDX(RD_SGL_IDX), .RD_BST_IDX(RD_BST_IDX),
      .WR_SGL_IDX(WR_SGL_IDX), .WR_BST_IDX(WR_BST_IDX)
   ) u_plan (
      .addr      (req_addr),
      .len       (req_len),
      .wr        (req_write),
      .op        (op_q),
      .run_idx   (run_idx_q),
      .nobrst    (nobrst_q),
      .start_idx (plan_start),
      .run_cnt   (plan_runs)
   );

   ucode_seq_exec #(.DEPTH(DEPTH), .CTL_W(CTL_W), .LEN_W(LEN_W)) u_exec (
      .clk       (clk),
      .rst_n     (rst_n),
      .req_valid (take),
      .start_idx (plan_start),
      .run_cnt   (plan_runs),
      .word      (cur_word),
      .rd_idx    (rd_idx),
      .ctl       (mem_ctl),
      .ack       (beat_ack),
      .busy      (busy),
      .done      (done),
      .err       (err)
   );

   // R5: the planner never hands an empty run count to the executor
   p_runs_nonzero_r5: assert property (@(posedge clk) disable iff (!rst_n)
      take |-> (plan_runs != '0));
   // R2: completion is reported only once per finished request
   p_done_single_r2: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);
endmodule

// File: tb/ucode_seq_bench.sv
`timescale 1ns/1ps
module ucode_seq_bench;
   localparam int DEPTH = 64;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        ram_we = 1'b0;
   logic [5:0]  ram_addr = '0;
   logic [17:0] ram_wdata = '0;
   logic        mode_we = 1'b0;
   logic [1:0]  mode_op = '0;
   logic [5:0]  mode_start = '0;
   logic        mode_nobrst = 1'b0;
   logic        req_valid = 1'b0;
   logic [31:0] req_addr = '0;
   logic [7:0]  req_len = '0;
   logic        req_write = 1'b0;
   logic [15:0] mem_ctl;
   logic        beat_ack, busy, done, err;

   int n_checks = 0;
   int n_fails  = 0;
   int cyc      = 0;
   bit err_exp  = 1'b0;

   logic [15:0] img_ctl  [DEPTH];
   bit          img_ack  [DEPTH];
   bit          img_last [DEPTH];

   int cur_op = 0;
   int cur_start = 0;
   bit cur_bi = 1'b0;

   always #4 clk = ~clk;

   ucode_seq u_ucode_seq (
      .clk(clk), .rst_n(rst_n),
      .ram_we(ram_we), .ram_addr(ram_addr), .ram_wdata(ram_wdata),
      .mode_we(mode_we), .mode_op(mode_op), .mode_start(mode_start),
      .mode_nobrst(mode_nobrst),
      .req_valid(req_valid), .req_addr(req_addr), .req_len(req_len),
      .req_write(req_write),
      .mem_ctl(mem_ctl), .beat_ack(beat_ack), .busy(busy), .done(done), .err(err)
   );

   task automatic check(input bit ok, input string req, input string what,
                        input longint act, input longint exp);
      n_checks++;
      if (!ok) begin
         n_fails++;
         $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
      end
   endtask

   function automatic int exp_start(input logic [31:0] a, input int n, input bit w);
      if (cur_op == 3 && w) return cur_start;
      if (!cur_bi && a[4:0] == 5'd0 && n != 0 && n % 32 == 0) return w ? 32 : 8;
      return w ? 24 : 0;
   endfunction

   function automatic int exp_runs(input logic [31:0] a, input int n, input bit w);
      if (cur_op == 3 && w) return 1;
      if (!cur_bi && a[4:0] == 5'd0 && n != 0 && n % 32 == 0) return n / 32;
      if (n == 0) return 1;
      return (n + 3) / 4;
   endfunction

   task automatic set_mode(input int op, input int st, input bit bi);
      @(negedge clk);
      mode_we = 1'b1; mode_op = 2'(op); mode_start = 6'(st); mode_nobrst = bi;
      @(negedge clk);
      mode_we = 1'b0;
      cur_op = op; cur_start = st; cur_bi = bi;
   endtask

   task automatic run_req(input logic [31:0] a, input int n, input bit w,
                          input bit junk, input string tag);
      int s, left, p, steps;
      bit bad, oerr;
      longint bad_act, bad_exp;
      s = exp_start(a, n, w);
      left = exp_runs(a, n, w);
      p = s; bad = 1'b0; oerr = 1'b0; steps = 0; bad_act = 0; bad_exp = 0;
      @(negedge clk);
      req_valid = 1'b1; req_addr = a; req_len = 8'(n); req_write = w;
      @(negedge clk);
      if (junk) begin
         req_addr = ~a; req_len = 8'd32; req_write = ~w;
      end else begin
         req_valid = 1'b0;
      end
      forever begin
         if (!bad && (!busy || mem_ctl != img_ctl[p] || beat_ack != img_ack[p])) begin
            bad = 1'b1;
            bad_act = {busy, beat_ack, mem_ctl};
            bad_exp = {1'b1, img_ack[p], img_ctl[p]};
         end
         steps++;
         if (img_last[p]) begin
            left--;
            if (left == 0) break;
            p = s;
         end else if (p == DEPTH - 1) begin
            oerr = 1'b1;
            break;
         end else begin
            p++;
         end
         @(negedge clk);
      end
      check(!bad, tag, "sequence {busy,ack,ctl}", bad_act, bad_exp);
      @(negedge clk);
      req_valid = 1'b0;
      err_exp = err_exp | oerr;
      check(!busy && done == !oerr, tag, "end {busy,done}", {busy, done}, {1'b0, !oerr});
      check(err == err_exp, (oerr ? "R9" : tag), "err flag", err, err_exp);
      @(negedge clk);
      check(!busy && !done, (junk ? "R8" : "R2"), "after end {busy,done}",
            {busy, done}, 2'b00);
   endtask

   initial begin : watchdog
      forever begin
         @(posedge clk);
         cyc++;
         if (cyc > 150000) begin
            n_checks++;
            n_fails++;
            $display("FAIL watchdog: actual %0d cycles expected fewer", cyc);
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
            $finish;
         end
      end
   end

   initial begin : main
      void'($urandom(32'd5171));
      for (int i = 0; i < DEPTH; i++) begin
         img_ctl[i]  = 16'(i * 16'h0301) ^ 16'h5A3C;
         img_ack[i]  = 1'b0;
         img_last[i] = (i < 52);
      end
      for (int b = 0; b <= 24; b += 24) begin
         img_last[b] = 0; img_ack[b+1] = 1; img_last[b+1] = 0; img_last[b+2] = 1;
      end
      for (int b = 8; b <= 32; b += 24) begin
         for (int k = 0; k < 9; k++) img_last[b+k] = 0;
         for (int k = 1; k <= 8; k++) img_ack[b+k] = 1;
         img_last[b+9] = 1;
      end
      img_last[48] = 0; img_last[49] = 0; img_last[50] = 1;

      repeat (3) @(negedge clk);
      // R1: reset state
      check(mem_ctl == 0 && !beat_ack && !busy && !done && !err, "R1", "reset outputs",
            {mem_ctl, beat_ack, busy, done, err}, 0);
      rst_n = 1'b1;
      for (int i = 0; i < DEPTH; i++) begin
         @(negedge clk);
         ram_we = 1'b1; ram_addr = 6'(i);
         ram_wdata = {img_last[i], img_ack[i], img_ctl[i]};
      end
      @(negedge clk);
      ram_we = 1'b0;
      check(mem_ctl == 0 && !busy, "R1", "idle after load", {busy, mem_ctl}, 0);

      run_req(32'h100, 4, 1'b0, 1'b0, "R3");
      run_req(32'h013, 1, 1'b1, 1'b0, "R3");
      run_req(32'h040, 32, 1'b0, 1'b0, "R4");
      run_req(32'h080, 64, 1'b1, 1'b0, "R4");
      run_req(32'h044, 32, 1'b0, 1'b0, "R5");
      run_req(32'h0C0, 40, 1'b1, 1'b0, "R5");
      run_req(32'h0C0, 0, 1'b0, 1'b0, "R5");
      run_req(32'h001, 255, 1'b0, 1'b0, "R5");
      set_mode(0, 0, 1'b1);
      run_req(32'h040, 32, 1'b0, 1'b0, "R6");
      run_req(32'h100, 96, 1'b1, 1'b0, "R6");
      set_mode(3, 48, 1'b0);
      run_req(32'h200, 4, 1'b1, 1'b0, "R7");
      run_req(32'h200, 32, 1'b0, 1'b0, "R7");
      set_mode(0, 0, 1'b0);
      run_req(32'h300, 64, 1'b0, 1'b1, "R8");
      run_req(32'h305, 9, 1'b1, 1'b1, "R8");
      set_mode(3, 52, 1'b0);
      run_req(32'h400, 4, 1'b1, 1'b0, "R9");
      set_mode(0, 0, 1'b0);
      run_req(32'h020, 4, 1'b0, 1'b0, "R9");

      for (int t = 0; t < 30; t++) begin
         logic [31:0] a;
         int n, kind;
         kind = int'($urandom % 4);
         a = $urandom;
         if ($urandom % 2 == 0) a[4:0] = 5'd0;
         case (kind)
            0: n = int'($urandom % 40);
            1: n = 32 * (1 + int'($urandom % 3));
            2: n = 1 + int'($urandom % 4);
            default: n = int'($urandom % 97);
         endcase
         set_mode(0, 0, 1'($urandom % 4 == 0));
         run_req(a, n, 1'($urandom % 2), 1'($urandom % 3 == 0), "R5");
      end

      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
      $finish;
   end
endmodule